// File: doc/BRIEF.md
# Demand-Driven Crossroad Signal Controller

This block sequences the lamps at a junction where a busy main road meets a quiet side road. The main road is given priority and shows green for as long as nobody waits on the side road. A one-bit vehicle detector on the side road starts a handover. The main road steps through yellow, then both roads show red, and then the side road turns green. The side road keeps green only while the detector still reports cars. When the detector clears, the side road steps through yellow and the main road takes green again.

Three phases are timed by a down-counter: main yellow, all-red, and side yellow. Their lengths come from two 8-bit cycle-count inputs. The counter is loaded when a timed phase is entered. A new value on either count input therefore applies only from the next phase that loads it. The other two phases end on the detector alone.

Top module: `crossroad_light_ctrl`

## Requirements
- R1: A synchronous active-high reset, taking effect at the next clock edge, puts the controller in its resting phase: main lamp green, side lamp red. This holds even when reset arrives in the middle of a handover.
- R2: Lamp codes are 2'b00 red, 2'b01 yellow and 2'b10 green. While the detector is 0 in the resting phase, the lamps stay main green and side red.
- R3: When the detector is 1 at a clock edge in the resting phase, the lamps show main yellow and side red from that edge.
- R4: Main yellow lasts exactly `amber_cycles` clock cycles. Both lamps then show red.
- R5: The all-red phase lasts exactly `allred_cycles` clock cycles. The lamps then show main red and side green.
- R6: Side green holds while the detector is 1. At the first edge that samples the detector as 0, the side lamp turns yellow and the main lamp stays red.
- R7: Side yellow lasts exactly `amber_cycles` clock cycles. The lamps then return to main green and side red.
- R8: A count value of 0 gives a timed phase of exactly 1 cycle.
- R9: A count value is captured when a timed phase is entered. Changing the count input during that phase does not change the phase's length.
- R10: The main and side lamps are never both non-red in the same cycle.
- R11: The detector is ignored during main yellow and all-red. If it drops to 0 during those phases, the handover still completes and side green is shown for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| side_req | input | 1 | Side-road detector, 1 when cars are waiting |
| amber_cycles | input | 8 | Length in cycles of each yellow phase (0 means 1) |
| allred_cycles | input | 8 | Length in cycles of the all-red phase (0 means 1) |
| main_lamp | output | 2 | Main-road lamp code |
| side_lamp | output | 2 | Side-road lamp code |

## Verification
Two events can fall in the same cycle: the timer expiring and a new count value being loaded. The count inputs are rewritten while a phase is still timing. One count serves both yellow phases, so its new value must appear only in the later yellow phase. Each phase length is judged by counting the cycles a lamp pattern is held. A second clash is the detector dropping during main yellow and all-red, before side green appears; this must yield a side green of exactly one cycle.

// File: rtl/crossroad_light_ctrl.sv
module crossroad_light_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             side_req,
  input  logic [CNT_W-1:0] amber_cycles,
  input  logic [CNT_W-1:0] allred_cycles,
  output logic [1:0]       main_lamp,
  output logic [1:0]       side_lamp
);
  localparam logic [1:0] LAMP_RED = 2'b00;
  localparam logic [1:0] LAMP_YEL = 2'b01;
  localparam logic [1:0] LAMP_GRN = 2'b10;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    PH_MAIN_GO, PH_MAIN_AMBER, PH_ALL_STOP, PH_SIDE_GO, PH_SIDE_AMBER
  } phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] tmr;
  logic             tmr_done;
  logic             timed;
  logic [CNT_W-1:0] amber_ld, allred_ld;

  assign tmr_done  = (tmr == '0);
  assign timed     = (phase == PH_MAIN_AMBER) || (phase == PH_ALL_STOP) || (phase == PH_SIDE_AMBER);
  assign amber_ld  = (amber_cycles  == '0) ? '0 : amber_cycles  - ONE;
  assign allred_ld = (allred_cycles == '0) ? '0 : allred_cycles - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_MAIN_GO;
      tmr   <= '0;
    end else begin
      case (phase)
        PH_MAIN_GO:
          if (side_req) begin
            phase <= PH_MAIN_AMBER;
            tmr   <= amber_ld;
          end
        PH_MAIN_AMBER:
          if (tmr_done) begin
            phase <= PH_ALL_STOP;
            tmr   <= allred_ld;
          end else tmr <= tmr - ONE;
        PH_ALL_STOP:
          if (tmr_done) begin
            phase <= PH_SIDE_GO;
            tmr   <= '0;
          end else tmr <= tmr - ONE;
        PH_SIDE_GO:
          if (!side_req) begin
            phase <= PH_SIDE_AMBER;
            tmr   <= amber_ld;
          end
        PH_SIDE_AMBER:
          if (tmr_done) begin
            phase <= PH_MAIN_GO;
            tmr   <= '0;
          end else tmr <= tmr - ONE;
        default: begin
          phase <= PH_MAIN_GO;
          tmr   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    main_lamp = LAMP_RED;
    side_lamp = LAMP_RED;
    case (phase)
      PH_MAIN_GO:    main_lamp = LAMP_GRN;
      PH_MAIN_AMBER: main_lamp = LAMP_YEL;
      PH_SIDE_GO:    side_lamp = LAMP_GRN;
      PH_SIDE_AMBER: side_lamp = LAMP_YEL;
      default: ;
    endcase
  end

  AST_RESET_REST: assert property (@(posedge clk)
    rst |=> (main_lamp == LAMP_GRN && side_lamp == LAMP_RED && tmr == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (main_lamp == LAMP_GRN && !side_req) |=> main_lamp == LAMP_GRN); // R2
  AST_REQ_START: assert property (@(posedge clk) disable iff (rst)
    (main_lamp == LAMP_GRN && side_req) |=> (main_lamp == LAMP_YEL && side_lamp == LAMP_RED)); // R3
  AST_SIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (side_lamp == LAMP_GRN && side_req) |=> side_lamp == LAMP_GRN); // R6
  AST_SIDE_DROP: assert property (@(posedge clk) disable iff (rst)
    (side_lamp == LAMP_GRN && !side_req) |=> (side_lamp == LAMP_YEL && main_lamp == LAMP_RED)); // R6
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    (timed && !tmr_done) |=> (phase == $past(phase) && tmr == $past(tmr) - ONE)); // R9
  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !(main_lamp != LAMP_RED && side_lamp != LAMP_RED)); // R10
endmodule

// File: tb/test_crossroad_light_ctrl.sv
module test_crossroad_light_ctrl;
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic side_req = 1'b0;
  logic [7:0] amber_cycles = 8'd3;
  logic [7:0] allred_cycles = 8'd2;
  logic [1:0] main_lamp, side_lamp;

  int n_checks = 0;
  int n_fail = 0;
  int conflicts = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crossroad_light_ctrl i_crossroad_light_ctrl (
    .clk(clk), .rst(rst), .side_req(side_req),
    .amber_cycles(amber_cycles), .allred_cycles(allred_cycles),
    .main_lamp(main_lamp), .side_lamp(side_lamp)
  );

  always @(negedge clk)
    if (!rst && main_lamp != RED && side_lamp != RED) conflicts++;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_lamps(string req, logic [1:0] m, logic [1:0] s);
    check({req, " main"}, int'(main_lamp), int'(m));
    check({req, " side"}, int'(side_lamp), int'(s));
  endtask

  task automatic hold_len(logic [1:0] m, logic [1:0] s, output int n);
    n = 0;
    while (main_lamp == m && side_lamp == s && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    side_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_lamps("R1 reset", GRN, RED);
    repeat (5) @(negedge clk);
    check_lamps("R2 idle rest", GRN, RED);
  endtask

  task automatic t_cycle(int amb, int ar);
    int n;
    int ea = (amb == 0) ? 1 : amb;
    int er = (ar == 0) ? 1 : ar;
    amber_cycles = 8'(amb);
    allred_cycles = 8'(ar);
    side_req = 1'b1;
    @(negedge clk);
    check_lamps("R3 start", YEL, RED);
    hold_len(YEL, RED, n);
    check((amb == 0) ? "R8 main yellow" : "R4 main yellow", n, ea);
    check_lamps("R4 all red", RED, RED);
    hold_len(RED, RED, n);
    check((ar == 0) ? "R8 all red" : "R5 all red", n, er);
    check_lamps("R5 side go", RED, GRN);
    repeat (3) @(negedge clk);
    check_lamps("R6 hold", RED, GRN);
    side_req = 1'b0;
    @(negedge clk);
    check_lamps("R6 drop", RED, YEL);
    hold_len(RED, YEL, n);
    check((amb == 0) ? "R8 side yellow" : "R7 side yellow", n, ea);
    check_lamps("R7 return", GRN, RED);
  endtask

  task automatic t_reload();
    int n;
    amber_cycles = 8'd4;
    allred_cycles = 8'd2;
    side_req = 1'b1;
    @(negedge clk);
    amber_cycles = 8'd9;
    hold_len(YEL, RED, n);
    check("R9 main yellow keeps old count", n, 4);
    hold_len(RED, RED, n);
    check("R9 all red", n, 2);
    side_req = 1'b0;
    hold_len(RED, GRN, n);
    hold_len(RED, YEL, n);
    check("R9 side yellow uses new count", n, 9);
    check_lamps("R9 return", GRN, RED);
  endtask

  task automatic t_early_drop();
    int n;
    amber_cycles = 8'd2;
    allred_cycles = 8'd3;
    side_req = 1'b1;
    @(negedge clk);
    side_req = 1'b0;
    hold_len(YEL, RED, n);
    check("R11 yellow completes", n, 2);
    hold_len(RED, RED, n);
    check("R11 all red completes", n, 3);
    hold_len(RED, GRN, n);
    check("R11 side green one cycle", n, 1);
    hold_len(RED, YEL, n);
    check("R11 side yellow", n, 2);
  endtask

  task automatic t_mid_reset();
    amber_cycles = 8'd2;
    allred_cycles = 8'd6;
    side_req = 1'b1;
    repeat (4) @(negedge clk);
    check_lamps("R1 pre-reset all red", RED, RED);
    rst = 1'b1;
    side_req = 1'b0;
    @(negedge clk);
    check_lamps("R1 mid reset", GRN, RED);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_lamps("R2 rest after reset", GRN, RED);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      check("R10 no conflicting lamps", conflicts, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cycle(3, 2);
    t_cycle(0, 0);
    t_cycle(1, 5);
    t_cycle(7, 1);
    t_reload();
    t_early_drop();
    t_mid_reset();
    finish_up();
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule